// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control decoder of a single-cycle 32-bit load/store datapath. It is purely combinational. It takes the 6-bit opcode from instruction bits 31:26 and the 6-bit function field from bits 5:0. From them it produces the 3-bit operation code for the ALU and the select and enable lines that steer the datapath multiplexers, the data memory and the register file.

The datapath wires the outputs straight into its multiplexers, so every output settles in the same cycle as the instruction word. Next-PC selection is outside this block. Branch and jump instructions only make sure that nothing is written.

Encodings that the block does not recognise are decoded to a safe default:
- no register write and no memory write;
- every select at zero;
- the ALU code set to ADD.

Top module: `ctrl_decode`

## Requirements
- R1: With opcode 0x00, funct 0x24/0x25/0x2A/0x20/0x22 drives alu_op to AND=000, OR=001, SLT=010, ADD=011 and SUB=100 respectively. These instructions use the register operand (alu_src_imm=0), take the destination from rd (dst_rt=0) and set reg_write=1.
- R2: Opcodes ANDI 0x0C, ORI 0x0D, SLTI 0x0A and ADDI 0x08 drive alu_op to AND, OR, SLT and ADD respectively. They also set alu_src_imm=1, dst_rt=1 and reg_write=1, with wb_from_mem=0.
- R3: Loads (LW 0x23, LB 0x20) drive alu_op=ADD and set alu_src_imm=1, dst_rt=1, wb_from_mem=1 and reg_write=1. They hold mem_write=0, which means read.
- R4: Stores (SW 0x2B, SB 0x28) drive alu_op=ADD and set alu_src_imm=1 and mem_write=1. They hold reg_write=0.
- R5: Branches (BEQ 0x04, BNE 0x05) drive alu_op=SUB with alu_src_imm=0. Both reg_write and mem_write are 0.
- R6: JAL (opcode 0x03) sets dst_link31=1, wb_link_pc8=1 and reg_write=1, with alu_op=ADD.
- R7: JALR (opcode 0x00, funct 0x09) sets wb_link_pc8=1 and reg_write=1 with dst_link31=0, so the link goes to rd.
- R8: J (opcode 0x02) and JR (opcode 0x00, funct 0x08) write nothing: reg_write=0 and mem_write=0. Their alu_op is ADD.
- R9: The selects stay narrow:
  - wb_from_mem is 1 only for loads;
  - wb_link_pc8 is 1 only for JAL and JALR;
  - dst_link31 is 1 only for JAL;
  - mem_write is 1 only for stores.
- R10: Any other opcode, or opcode 0x00 with any other funct, gives reg_write=0, mem_write=0, alu_op=ADD (011) and all selects 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 6 | Opcode, instruction bits 31:26 |
| funct_i | input | 6 | Function field, instruction bits 5:0 |
| alu_op_o | output | 3 | ALU operation code |
| alu_src_imm_o | output | 1 | 1: second ALU operand is the sign-extended immediate |
| wb_from_mem_o | output | 1 | 1: write-back data comes from memory read data |
| dst_rt_o | output | 1 | 1: destination register field is bits 20:16 |
| dst_link31_o | output | 1 | 1: destination register forced to 31 |
| wb_link_pc8_o | output | 1 | 1: write-back data is PC+8 |
| mem_write_o | output | 1 | Data memory control, 0 read / 1 write |
| reg_write_o | output | 1 | Register file write enable |

## Verification
The decoder has no parameters, so the bench builds it exactly as it is used. Because the input space is only 4096 opcode/funct pairs, the bench first runs directed tasks per instruction class and then sweeps every pair against a reference table written from the requirements. That sweep reaches every unlisted encoding, including the unlisted funct values under opcode 0x00 and opcodes that differ from a listed one by a single bit.

// File: rtl/ctrl_decode.sv
module ctrl_decode (
  input  logic [5:0] op_i,
  input  logic [5:0] funct_i,
  output logic [2:0] alu_op_o,
  output logic       alu_src_imm_o,
  output logic       wb_from_mem_o,
  output logic       dst_rt_o,
  output logic       dst_link31_o,
  output logic       wb_link_pc8_o,
  output logic       mem_write_o,
  output logic       reg_write_o
);
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_SLT = 3'b010;
  localparam logic [2:0] OP_ADD = 3'b011;
  localparam logic [2:0] OP_SUB = 3'b100;

  always_comb begin
    alu_op_o      = OP_ADD;
    alu_src_imm_o = 1'b0;
    wb_from_mem_o = 1'b0;
    dst_rt_o      = 1'b0;
    dst_link31_o  = 1'b0;
    wb_link_pc8_o = 1'b0;
    mem_write_o   = 1'b0;
    reg_write_o   = 1'b0;
    unique case (op_i)
      6'h00: begin
        unique case (funct_i)
          6'h24: begin alu_op_o = OP_AND; reg_write_o = 1'b1; end
          6'h25: begin alu_op_o = OP_OR;  reg_write_o = 1'b1; end
          6'h2A: begin alu_op_o = OP_SLT; reg_write_o = 1'b1; end
          6'h20: begin alu_op_o = OP_ADD; reg_write_o = 1'b1; end
          6'h22: begin alu_op_o = OP_SUB; reg_write_o = 1'b1; end
          6'h09: begin wb_link_pc8_o = 1'b1; reg_write_o = 1'b1; end
          default: ;
        endcase
      end
      6'h0C, 6'h0D, 6'h0A, 6'h08: begin
        alu_src_imm_o = 1'b1;
        dst_rt_o      = 1'b1;
        reg_write_o   = 1'b1;
        alu_op_o      = (op_i == 6'h0C) ? OP_AND :
                        (op_i == 6'h0D) ? OP_OR  :
                        (op_i == 6'h0A) ? OP_SLT : OP_ADD;
      end
      6'h23, 6'h20: begin
        alu_src_imm_o = 1'b1;
        dst_rt_o      = 1'b1;
        wb_from_mem_o = 1'b1;
        reg_write_o   = 1'b1;
      end
      6'h2B, 6'h28: begin
        alu_src_imm_o = 1'b1;
        mem_write_o   = 1'b1;
      end
      6'h04, 6'h05: alu_op_o = OP_SUB;
      6'h03: begin
        dst_link31_o  = 1'b1;
        wb_link_pc8_o = 1'b1;
        reg_write_o   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ctrl_decode_chk.sv
module ctrl_decode_chk (
  input logic [2:0] alu_op_o,
  input logic       alu_src_imm_o,
  input logic       wb_from_mem_o,
  input logic       dst_rt_o,
  input logic       dst_link31_o,
  input logic       wb_link_pc8_o,
  input logic       mem_write_o,
  input logic       reg_write_o
);
  always_comb begin
    AST_ALU_CODE_LEGAL: assert (alu_op_o <= 3'b100);                                         // R1
    AST_LOAD_SHAPE: assert (!wb_from_mem_o || (alu_src_imm_o && dst_rt_o && reg_write_o));   // R3
    AST_STORE_NO_REGWR: assert (!mem_write_o || (!reg_write_o && alu_src_imm_o));            // R4
    AST_LINK31_SHAPE: assert (!dst_link31_o || (wb_link_pc8_o && reg_write_o));              // R6
    AST_WB_SRC_EXCL: assert (!(wb_from_mem_o && wb_link_pc8_o));                             // R9
    AST_RT_IMM: assert (!dst_rt_o || alu_src_imm_o);                                         // R2
  end
endmodule

bind ctrl_decode ctrl_decode_chk u_chk (
  .alu_op_o(alu_op_o), .alu_src_imm_o(alu_src_imm_o), .wb_from_mem_o(wb_from_mem_o),
  .dst_rt_o(dst_rt_o), .dst_link31_o(dst_link31_o), .wb_link_pc8_o(wb_link_pc8_o),
  .mem_write_o(mem_write_o), .reg_write_o(reg_write_o)
);

// File: tb/ctrl_decode_tb.sv
module ctrl_decode_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [5:0] op, fn;
  logic [2:0] alu_op;
  logic imm, mem, rt, l31, pc8, mw, rw;
  int n_chk = 0;
  int n_bad = 0;

  ctrl_decode u_dut (
    .op_i(op), .funct_i(fn), .alu_op_o(alu_op), .alu_src_imm_o(imm),
    .wb_from_mem_o(mem), .dst_rt_o(rt), .dst_link31_o(l31),
    .wb_link_pc8_o(pc8), .mem_write_o(mw), .reg_write_o(rw)
  );

  // Packed layout: [9:7] alu, [6] imm, [5] mem, [4] rt, [3] link31, [2] pc8, [1] mem_write, [0] reg_write
  function automatic logic [9:0] ref_dec(input logic [5:0] o, input logic [5:0] f);
    logic [9:0] r;
    r = {3'b011, 7'b0};
    case (o)
      6'h00: case (f)
        6'h24: r = {3'b000, 7'b0000001};
        6'h25: r = {3'b001, 7'b0000001};
        6'h2A: r = {3'b010, 7'b0000001};
        6'h20: r = {3'b011, 7'b0000001};
        6'h22: r = {3'b100, 7'b0000001};
        6'h09: r = {3'b011, 7'b0000101};
        default: ;
      endcase
      6'h0C: r = {3'b000, 7'b1010001};
      6'h0D: r = {3'b001, 7'b1010001};
      6'h0A: r = {3'b010, 7'b1010001};
      6'h08: r = {3'b011, 7'b1010001};
      6'h23, 6'h20: r = {3'b011, 7'b1110001};
      6'h2B, 6'h28: r = {3'b011, 7'b1000010};
      6'h04, 6'h05: r = {3'b100, 7'b0000000};
      6'h03: r = {3'b011, 7'b0001101};
      default: ;
    endcase
    return r;
  endfunction

  task automatic apply_check(input logic [5:0] o, input logic [5:0] f, input string tag);
    logic [9:0] got, exp;
    @(negedge clk);
    op = o; fn = f;
    #5;
    got = {alu_op, imm, mem, rt, l31, pc8, mw, rw};
    exp = ref_dec(o, f);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%h fn=%h actual=%b expected=%b", tag, o, f, got, exp);
    end
  endtask

  task automatic t_zero_word();
    apply_check(6'h00, 6'h00, "R10_zero_word");
  endtask

  task automatic t_rtype();
    apply_check(6'h00, 6'h24, "R1_and");
    apply_check(6'h00, 6'h25, "R1_or");
    apply_check(6'h00, 6'h2A, "R1_slt");
    apply_check(6'h00, 6'h20, "R1_add");
    apply_check(6'h00, 6'h22, "R1_sub");
  endtask

  task automatic t_itype();
    apply_check(6'h0C, 6'h3F, "R2_andi");
    apply_check(6'h0D, 6'h00, "R2_ori");
    apply_check(6'h0A, 6'h22, "R2_slti");
    apply_check(6'h08, 6'h09, "R2_addi");
  endtask

  task automatic t_mem();
    apply_check(6'h23, 6'h00, "R3_lw");
    apply_check(6'h20, 6'h2A, "R3_lb");
    apply_check(6'h2B, 6'h00, "R4_sw");
    apply_check(6'h28, 6'h24, "R4_sb");
  endtask

  task automatic t_flow();
    apply_check(6'h04, 6'h00, "R5_beq");
    apply_check(6'h05, 6'h20, "R5_bne");
    apply_check(6'h03, 6'h00, "R6_jal");
    apply_check(6'h00, 6'h09, "R7_jalr");
    apply_check(6'h02, 6'h00, "R8_j");
    apply_check(6'h00, 6'h08, "R8_jr");
  endtask

  task automatic t_unlisted();
    apply_check(6'h00, 6'h21, "R10_funct_neighbour");
    apply_check(6'h01, 6'h24, "R10_op_neighbour");
    apply_check(6'h29, 6'h00, "R10_near_store");
    apply_check(6'h3F, 6'h3F, "R10_all_ones");
  endtask

  task automatic t_sweep();
    for (int o = 0; o < 64; o++)
      for (int f = 0; f < 64; f++)
        apply_check(o[5:0], f[5:0], "R9_R10_sweep");
  endtask

  initial begin
    op = 6'h00; fn = 6'h00;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_zero_word();
    t_rtype();
    t_itype();
    t_mem();
    t_flow();
    t_unlisted();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule